// File: doc/BRIEF.md
# Code Phase Delay Loader

This block keeps one pending code-phase delay for each channel of a spreading-code generator and hands it to the generator at that channel's next load point. The delay word is 19 bits wide and mixed-radix, so it cannot be treated as a plain binary number. Bits 2:0 give eighths of a code chip. Bits 12:3 give whole chips, from 0 to 1022. Bits 18:13 give whole milliseconds. A chip value of 1023 is not legal and is never stored.

Software writes a word to a channel. That channel's busy flag then rises and stays high until the generator raises the channel's load-point input. At that point the block copies the word to the channel's delay output, pulses a one-cycle load strobe and drops the flag. A new word is accepted only while the flag is low. A word that arrives while the flag is high is dropped and recorded in a sticky overrun bit.

A slew input moves a channel's pending delay forward by one eighth of a chip. The step carries through all three fields and skips the illegal chip value. The block then treats the stepped value like a fresh write and raises the busy flag.

Top module: `code_phase_loader`

## Requirements
- R1: After reset, the busy, overrun, range-error and load-strobe outputs are all zero, and every channel's delay output is zero.
- R2: A write to a channel whose busy flag is low raises that channel's busy flag in the next cycle. It changes no other channel's flag. A write to a channel number of 12 or above is ignored.
- R3: A load-point pulse on a busy channel does three things in the next cycle: it pulses that channel's load strobe for exactly one cycle, it puts the pending word on the channel's 19-bit delay slice, and it clears the busy flag. The slice for channel c is delayOut[19c+18:19c]. Within the slice, bits 2:0 are eighths of a chip, bits 12:3 are chips and bits 18:13 are milliseconds.
- R4: A load-point pulse on a channel that is not busy produces no strobe and leaves the delay slice unchanged.
- R5: A written word whose chip field (bits 12:3) is 1023 is stored with that field set to 1022, and the other two fields are kept. The channel's range-error bit is set and stays set until reset.
- R6: A write to a busy channel is ignored: the pending word is kept. The channel's overrun bit is set and stays set until reset.
- R7: A slew on an idle channel adds one eighth of a chip to the pending word and raises busy. When the eighths field is 7, the step sets it to 0 and adds one to the chip field.
- R8: When a step carries out of a chip field of 1022, the chip field becomes 0 and the millisecond field goes up by one. The millisecond field wraps from 63 to 0.
- R9: A slew on a busy channel is ignored and does not set overrun. When a write and a slew reach the same idle channel in the same cycle, the write is taken and the slew is dropped.
- R10: A delay slice never shows a chip value of 1023. It changes only in the cycle in which its load strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write request for the delay word |
| wrChan | input | 4 | Channel number of the write |
| wrData | input | 19 | Mixed-radix delay word |
| slewEn | input | 1 | Request to step the pending delay by one eighth chip |
| slewChan | input | 4 | Channel number of the slew |
| loadPoint | input | 12 | Per-channel load point from the code generator |
| busy | output | 12 | Per-channel pending-update flag |
| overrun | output | 12 | Sticky flag: a write arrived while the channel was busy |
| rangeErr | output | 12 | Sticky flag: a write carried the illegal chip value |
| loadStrobe | output | 12 | One-cycle pulse marking a transfer to the generator |
| delayOut | output | 228 | Loaded delay for each channel, 19 bits per channel |

## Verification
Writes and slews are registered in a single stage, so busy, range-error and overrun all change one cycle after the request. A load point also takes one cycle: the strobe, the new delay slice and the dropped busy flag appear together in the next cycle, and the strobe falls one cycle after that. The bench drives every input on the falling edge and holds it for exactly one rising edge. It checks on the following falling edge, so each result is sampled in the first cycle it is due. It then checks the strobe once more a cycle later to confirm that the pulse is a single cycle long. Requirements about ignored requests are checked at the ports: the bench loads the channel afterwards and compares the delay slice with the word that should have survived.

// File: rtl/cpdl_pkg.sv
package cpdl_pkg;

  parameter int FRAC_W = 3;
  parameter int CHIP_W = 10;
  parameter int MS_W   = 6;

  localparam int DLY_W = FRAC_W + CHIP_W + MS_W;

  localparam logic [CHIP_W-1:0] CHIP_BAD  = '1;
  localparam logic [CHIP_W-1:0] CHIP_LAST = CHIP_BAD - 1'b1;

  // Field order follows bit order: milliseconds on top, eighths at the bottom.
  typedef struct packed {
    logic [MS_W-1:0]   ms;
    logic [CHIP_W-1:0] chip;
    logic [FRAC_W-1:0] frac;
  } delay_t;

  // Per-channel strobes from control to datapath.
  typedef struct packed {
    logic takeWr;
    logic takeSlew;
    logic xfer;
  } chanCtl_t;

  function automatic delay_t clampChip(input delay_t d);
    delay_t r;
    r = d;
    if (d.chip == CHIP_BAD) r.chip = CHIP_LAST;
    return r;
  endfunction

  // Advance by one eighth chip with mixed-radix carries.
  function automatic delay_t advanceEighth(input delay_t d);
    delay_t r;
    r = d;
    if (d.frac != '1) begin
      r.frac = d.frac + 1'b1;
    end else begin
      r.frac = '0;
      if (d.chip >= CHIP_LAST) begin
        r.chip = '0;
        r.ms   = d.ms + 1'b1;
      end else begin
        r.chip = d.chip + 1'b1;
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/cpdl_ctrl.sv
module cpdl_ctrl
  import cpdl_pkg::*;
#(
  parameter int NUM_CH = 12,
  parameter int CH_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [CH_W-1:0]   wrChan,
  input  logic              wrChipBad,
  input  logic              slewEn,
  input  logic [CH_W-1:0]   slewChan,
  input  logic [NUM_CH-1:0] loadPoint,
  output chanCtl_t          ctl [NUM_CH],
  output logic [NUM_CH-1:0] busy,
  output logic [NUM_CH-1:0] overrun,
  output logic [NUM_CH-1:0] rangeErr,
  output logic [NUM_CH-1:0] loadStrobe
);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    logic hitWr;
    logic hitSlew;

    always_comb begin
      hitWr   = wrEn && (wrChan == CH_W'(c));
      hitSlew = slewEn && (slewChan == CH_W'(c)) && !hitWr;
      ctl[c].takeWr   = hitWr && !busy[c];
      ctl[c].takeSlew = hitSlew && !busy[c];
      ctl[c].xfer     = loadPoint[c] && busy[c];
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        busy[c]       <= 1'b0;
        overrun[c]    <= 1'b0;
        rangeErr[c]   <= 1'b0;
        loadStrobe[c] <= 1'b0;
      end else begin
        if (ctl[c].takeWr || ctl[c].takeSlew) busy[c] <= 1'b1;
        else if (ctl[c].xfer)                 busy[c] <= 1'b0;
        if (hitWr && busy[c])            overrun[c]  <= 1'b1;
        if (ctl[c].takeWr && wrChipBad)  rangeErr[c] <= 1'b1;
        loadStrobe[c] <= ctl[c].xfer;
      end
    end
  end

endmodule

// File: rtl/cpdl_datapath.sv
module cpdl_datapath
  import cpdl_pkg::*;
#(
  parameter int NUM_CH = 12
) (
  input  logic     clk,
  input  logic     rst_n,
  input  chanCtl_t ctl [NUM_CH],
  input  delay_t   wrWord,
  output delay_t   loaded [NUM_CH]
);

  delay_t wrClean;
  assign wrClean = clampChip(wrWord);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    delay_t held;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        held      <= '0;
        loaded[c] <= '0;
      end else begin
        if (ctl[c].takeWr)        held <= wrClean;
        else if (ctl[c].takeSlew) held <= advanceEighth(held);
        if (ctl[c].xfer)          loaded[c] <= held;
      end
    end
  end

endmodule

// File: rtl/code_phase_loader.sv
module code_phase_loader
  import cpdl_pkg::*;
#(
  parameter int NUM_CH = 12,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wrEn,
  input  logic [CH_W-1:0]         wrChan,
  input  logic [DLY_W-1:0]        wrData,
  input  logic                    slewEn,
  input  logic [CH_W-1:0]         slewChan,
  input  logic [NUM_CH-1:0]       loadPoint,
  output logic [NUM_CH-1:0]       busy,
  output logic [NUM_CH-1:0]       overrun,
  output logic [NUM_CH-1:0]       rangeErr,
  output logic [NUM_CH-1:0]       loadStrobe,
  output logic [NUM_CH*DLY_W-1:0] delayOut
);

  chanCtl_t ctl [NUM_CH];
  delay_t   loaded [NUM_CH];
  delay_t   wrWord;
  logic     wrChipBad;

  assign wrWord    = delay_t'(wrData);
  assign wrChipBad = (wrWord.chip == CHIP_BAD);

  cpdl_ctrl #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .wrEn       (wrEn),
    .wrChan     (wrChan),
    .wrChipBad  (wrChipBad),
    .slewEn     (slewEn),
    .slewChan   (slewChan),
    .loadPoint  (loadPoint),
    .ctl        (ctl),
    .busy       (busy),
    .overrun    (overrun),
    .rangeErr   (rangeErr),
    .loadStrobe (loadStrobe)
  );

  cpdl_datapath #(.NUM_CH(NUM_CH)) u_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .ctl    (ctl),
    .wrWord (wrWord),
    .loaded (loaded)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_flat
    assign delayOut[c*DLY_W +: DLY_W] = loaded[c];
  end

endmodule

// File: rtl/cpdl_checker.sv
module cpdl_checker
  import cpdl_pkg::*;
#(
  parameter int NUM_CH = 12,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    wrEn,
  input logic [CH_W-1:0]         wrChan,
  input logic [DLY_W-1:0]        wrData,
  input logic                    slewEn,
  input logic [CH_W-1:0]         slewChan,
  input logic [NUM_CH-1:0]       loadPoint,
  input logic [NUM_CH-1:0]       busy,
  input logic [NUM_CH-1:0]       overrun,
  input logic [NUM_CH-1:0]       rangeErr,
  input logic [NUM_CH-1:0]       loadStrobe,
  input logic [NUM_CH*DLY_W-1:0] delayOut
);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    logic wrHit;
    logic slewOnly;
    assign wrHit    = wrEn && (wrChan == CH_W'(c));
    assign slewOnly = slewEn && (slewChan == CH_W'(c)) && !wrHit;

    // R2
    busy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wrHit && !busy[c]) |=> busy[c]);

    // R3
    load_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (loadPoint[c] && busy[c]) |=> (loadStrobe[c] && !busy[c]));

    // R4
    no_idle_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(loadPoint[c] && busy[c]) |=> !loadStrobe[c]);

    // R5
    range_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wrHit && !busy[c] && wrData[FRAC_W +: CHIP_W] == CHIP_BAD) |=> rangeErr[c]);

    // R5
    range_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rangeErr[c] |=> rangeErr[c]);

    // R6
    overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wrHit && busy[c]) |=> overrun[c]);

    // R6
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      overrun[c] |=> overrun[c]);

    // R9
    slew_no_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (slewOnly && busy[c] && !overrun[c]) |=> !overrun[c]);

    // R10
    chip_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      delayOut[c*DLY_W + FRAC_W +: CHIP_W] != CHIP_BAD);

    // R10
    out_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(loadPoint[c] && busy[c]) |=> $stable(delayOut[c*DLY_W +: DLY_W]));
  end

endmodule

bind code_phase_loader cpdl_checker #(.NUM_CH(NUM_CH)) u_chk (.*);

// File: tb/code_phase_loader_bench.sv
module code_phase_loader_bench;
  localparam int NUM_CH = 12;
  localparam int CH_W   = 4;
  localparam int DW     = 19;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 wrEn = 1'b0;
  logic [CH_W-1:0]      wrChan = '0;
  logic [DW-1:0]        wrData = '0;
  logic                 slewEn = 1'b0;
  logic [CH_W-1:0]      slewChan = '0;
  logic [NUM_CH-1:0]    loadPoint = '0;
  logic [NUM_CH-1:0]    busy, overrun, rangeErr, loadStrobe;
  logic [NUM_CH*DW-1:0] delayOut;

  int nChk = 0;
  int nFail = 0;

  always #4 clk = ~clk;  // 8 ns period

  code_phase_loader u_code_phase_loader (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrChan(wrChan), .wrData(wrData),
    .slewEn(slewEn), .slewChan(slewChan), .loadPoint(loadPoint),
    .busy(busy), .overrun(overrun), .rangeErr(rangeErr),
    .loadStrobe(loadStrobe), .delayOut(delayOut)
  );

  // word layout: ms[18:13], chip[12:3], eighths[2:0]
  typedef struct packed {
    logic [3:0]    ch;
    logic [DW-1:0] wr;
    logic [DW-1:0] exp;
    logic          err;
  } vec_t;

  localparam vec_t VECS [0:3] = '{
    '{4'd0,  {6'd5,  10'd100,  3'd3}, {6'd5,  10'd100,  3'd3}, 1'b0},
    '{4'd5,  {6'd63, 10'd1022, 3'd7}, {6'd63, 10'd1022, 3'd7}, 1'b0},
    '{4'd11, {6'd0,  10'd1023, 3'd2}, {6'd0,  10'd1022, 3'd2}, 1'b1},
    '{4'd3,  {6'd17, 10'd0,    3'd0}, {6'd17, 10'd0,    3'd0}, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    nChk++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] slice(input int ch);
    return 32'(delayOut[ch*DW +: DW]);
  endfunction

  task automatic doWrite(input int ch, input logic [DW-1:0] d);
    @(negedge clk); wrEn = 1'b1; wrChan = CH_W'(ch); wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic doSlew(input int ch);
    @(negedge clk); slewEn = 1'b1; slewChan = CH_W'(ch);
    @(negedge clk); slewEn = 1'b0;
  endtask

  task automatic doLoad(input int ch);
    @(negedge clk); loadPoint = NUM_CH'(1) << ch;
    @(negedge clk); loadPoint = '0;
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL R1: watchdog expired, got 0 expected 1");
    finishRun();
  end

  initial begin
    logic [31:0] keep;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", 32'(busy), 0);
    chk("R1 overrun", 32'(overrun), 0);
    chk("R1 rangeErr", 32'(rangeErr), 0);
    chk("R1 strobe", 32'(loadStrobe), 0);
    chk("R1 delayOut", 32'(|delayOut), 0);

    // table walk: R2, R3, R5
    for (int i = 0; i < 4; i++) begin
      doWrite(int'(VECS[i].ch), VECS[i].wr);
      chk("R2 busy one-hot", 32'(busy), 32'(NUM_CH'(1) << VECS[i].ch));
      chk("R5 rangeErr", 32'(rangeErr[VECS[i].ch]), 32'(VECS[i].err));
      doLoad(int'(VECS[i].ch));
      chk("R3 strobe", 32'(loadStrobe), 32'(NUM_CH'(1) << VECS[i].ch));
      chk("R3 delay", slice(int'(VECS[i].ch)), 32'(VECS[i].exp));
      chk("R3 busy clear", 32'(busy), 0);
      @(negedge clk);
      chk("R3 single pulse", 32'(loadStrobe), 0);
    end
    chk("R5 sticky", 32'(rangeErr), 32'(NUM_CH'(1) << 11));

    // R2 out-of-range channel ignored
    doWrite(13, {6'd1, 10'd1, 3'd1});
    chk("R2 bad channel", 32'(busy), 0);

    // R4 load point on idle channel
    doLoad(0);
    chk("R4 no strobe", 32'(loadStrobe), 0);
    chk("R4 delay kept", slice(0), 32'({6'd5, 10'd100, 3'd3}));

    // R6 write while busy
    doWrite(1, {6'd2, 10'd200, 3'd4});
    doWrite(1, {6'd9, 10'd9, 3'd1});
    chk("R6 overrun", 32'(overrun), 32'(NUM_CH'(1) << 1));
    doLoad(1);
    chk("R6 first word kept", slice(1), 32'({6'd2, 10'd200, 3'd4}));

    // R7 eighth steps and carry into chips
    doWrite(2, {6'd0, 10'd5, 3'd7});
    doLoad(2);
    doSlew(2);
    chk("R7 slew busy", 32'(busy[2]), 1);
    doLoad(2);
    chk("R7 carry", slice(2), 32'({6'd0, 10'd6, 3'd0}));
    doSlew(2);
    doLoad(2);
    chk("R7 plain step", slice(2), 32'({6'd0, 10'd6, 3'd1}));

    // R8 chip wrap into ms, ms wrap
    doWrite(4, {6'd10, 10'd1022, 3'd7});
    doLoad(4);
    doSlew(4);
    doLoad(4);
    chk("R8 chip wrap", slice(4), 32'({6'd11, 10'd0, 3'd0}));
    doWrite(4, {6'd63, 10'd1022, 3'd7});
    doLoad(4);
    doSlew(4);
    doLoad(4);
    chk("R8 ms wrap", slice(4), 0);

    // R9 slew on busy channel ignored, no overrun
    doWrite(6, {6'd3, 10'd30, 3'd3});
    doSlew(6);
    chk("R9 no overrun", 32'(overrun[6]), 0);
    doLoad(6);
    chk("R9 slew dropped", slice(6), 32'({6'd3, 10'd30, 3'd3}));
    // R9 write and slew together: write wins
    @(negedge clk);
    wrEn = 1'b1; wrChan = 4'd6; wrData = {6'd8, 10'd80, 3'd0};
    slewEn = 1'b1; slewChan = 4'd6;
    @(negedge clk); wrEn = 1'b0; slewEn = 1'b0;
    doLoad(6);
    chk("R9 write wins", slice(6), 32'({6'd8, 10'd80, 3'd0}));

    // R10 slice holds between loads
    keep = slice(5);
    repeat (20) @(negedge clk);
    chk("R10 hold", slice(5), keep);
    chk("R10 hold strobe", 32'(loadStrobe), 0);

    finishRun();
  end
endmodule